// File: doc/BRIEF.md
# Auxiliary PWM Generator with Deferred Reload

A single-channel pulse-width generator whose time base is a free-running up-counter. Two live registers fix the cycle length (the counter's top value) and the compare point that splits each cycle into an asserted part and a deasserted part. Software reaches the block through a plain word-wide read/write port with byte-offset addresses.

A second pair of staging registers lets software queue a new length and compare point while the waveform is running. The queued pair moves into the live pair only on the clock where the counter rolls over, so the cycle in progress always completes with the values it started with. A control word starts and stops the counter, gates the output, picks which half of the cycle the compare value describes, and carries a two-bit field that turns off an external synchronisation input. That input is not part of this block.

The output is registered. It reflects the counter value of the previous clock, so it is free of glitches.

Top module: `apwm_top`

## Requirements
- R1: After reset every register reads 0, the counter stands at 0 and `pwm_out` is low.
- R2: Reads at offsets 0x08 (live length), 0x0C (live compare), 0x10 (staged length), 0x14 (staged compare) and 0x2A (control, 16 bits, zero-extended) return the last written value. Any other offset reads 0.
- R3: The counter advances only while control bit 4 (run) is 1. It counts from 0 up to the live length L, and on the clock after reaching L (or any value at or above L) it returns to 0. A cycle therefore lasts L+1 clocks. With bit 4 at 0 the counter holds its value.
- R4: With control bit 9 (output enable) at 1 and bit 10 (invert) at 0, `pwm_out` is 1 on the clock after a counter value below the live compare C, and 0 otherwise. C = 0 gives a constant 0, and C > L gives a constant 1.
- R5: With bit 10 at 1, the level defined in R4 is inverted, so C sets the low time.
- R6: With bit 9 at 0, `pwm_out` is 0 from the next clock on. Writing 0 to control stops the counter and drives the output low.
- R7: A write to the staged length or staged compare leaves the live values and the running cycle unchanged. At the next rollover both staged values are copied into the live registers.
- R8: The copy in R7 happens only if a staged register was written since the last copy. A rollover with nothing staged leaves the live registers as they are, including values written directly.
- R9: A write to the live length or live compare takes effect from the next clock. If it lands on the same clock as a rollover copy, the direct write wins.
- R10: A live length of 0 behaves as a length of 1, so the counter alternates between 0 and 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe for one clock |
| bus_addr | input | AW (8) | Byte offset of the accessed register |
| bus_wdata | input | W (32) | Write data |
| bus_rdata | output | W (32) | Read data, combinational from `bus_addr` |
| pwm_out | output | 1 | Registered waveform output |

## Verification
The hardest situation to reach is a rollover with staged values pending, followed by a direct write to a live register and a later rollover with nothing staged. Only that sequence shows whether the pending flag really clears. The bench first stages a new length in the middle of a long cycle and reads the live length back before and after the boundary. It then overwrites the live length and runs past several more rollovers before reading it again. Throughout, a cycle-by-cycle model built from the requirements predicts `pwm_out`. A sweep covers every short length, including 0, against every compare value up to beyond the length, in both polarities. The sweep also covers the halt and gated states.

// File: rtl/apwm_pkg.sv
package apwm_pkg;
  // Byte offsets decoded by the bus side.
  localparam logic [7:0] OFS_LIVE_LEN = 8'h08;
  localparam logic [7:0] OFS_LIVE_CMP = 8'h0C;
  localparam logic [7:0] OFS_STG_LEN  = 8'h10;
  localparam logic [7:0] OFS_STG_CMP  = 8'h14;
  localparam logic [7:0] OFS_CTRL     = 8'h2A;

  localparam int CTRL_W   = 16;
  localparam int B_INVERT = 10;
  localparam int B_OUTEN  = 9;
  localparam int B_RUN    = 4;
endpackage

// File: rtl/apwm_regs.sv
module apwm_regs #(
  parameter int W  = 32,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wdata,
  input  logic          rollover,
  output logic [W-1:0]  live_len,
  output logic [W-1:0]  live_cmp,
  output logic          run,
  output logic          outen,
  output logic          invert,
  output logic [W-1:0]  rdata
);
  import apwm_pkg::*;

  localparam int NREG = 2;

  logic [W-1:0]      live_q  [NREG];
  logic [W-1:0]      stg_q   [NREG];
  logic [CTRL_W-1:0] ctrl_q;
  logic              pend_q;

  // Named events for the assertions.
  logic wr_live_any, wr_stg_any, copy_evt;

  function automatic logic [AW-1:0] ofs(input logic [7:0] o);
    return AW'(o);
  endfunction

  logic [AW-1:0] live_ofs [NREG];
  logic [AW-1:0] stg_ofs  [NREG];
  assign live_ofs[0] = ofs(OFS_LIVE_LEN);
  assign live_ofs[1] = ofs(OFS_LIVE_CMP);
  assign stg_ofs[0]  = ofs(OFS_STG_LEN);
  assign stg_ofs[1]  = ofs(OFS_STG_CMP);

  assign copy_evt = rollover && pend_q;

  logic [NREG-1:0] wl, ws;
  for (genvar i = 0; i < NREG; i++) begin : g_pair
    assign wl[i] = we && (addr == live_ofs[i]);
    assign ws[i] = we && (addr == stg_ofs[i]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        live_q[i] <= '0;
        stg_q[i]  <= '0;
      end else begin
        if (wl[i])          live_q[i] <= wdata;      // direct write wins
        else if (copy_evt)  live_q[i] <= stg_q[i];
        if (ws[i])          stg_q[i]  <= wdata;
      end
    end
  end

  assign wr_live_any = |wl;
  assign wr_stg_any  = |ws;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      pend_q <= 1'b0;
    end else begin
      if (we && addr == ofs(OFS_CTRL)) ctrl_q <= wdata[CTRL_W-1:0];
      if (wr_stg_any)     pend_q <= 1'b1;
      else if (copy_evt)  pend_q <= 1'b0;
    end
  end

  assign live_len = live_q[0];
  assign live_cmp = live_q[1];
  assign run      = ctrl_q[B_RUN];
  assign outen    = ctrl_q[B_OUTEN];
  assign invert   = ctrl_q[B_INVERT];

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NREG; i++) begin
      if (addr == live_ofs[i]) rdata = live_q[i];
      if (addr == stg_ofs[i])  rdata = stg_q[i];
    end
    if (addr == ofs(OFS_CTRL)) rdata = W'(ctrl_q);
  end

  // R7: a pending stage reaches the live length at rollover
  a_r7_copy: assert property (@(posedge clk) disable iff (!rst_n)
    (copy_evt && !wl[0]) |=> live_q[0] == $past(stg_q[0]));
  // R8: rollover with nothing staged keeps the live length
  a_r8_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (rollover && !pend_q && !wr_live_any) |=> $stable(live_q[0]));
  // R9: a direct write lands on the next clock
  a_r9_direct: assert property (@(posedge clk) disable iff (!rst_n)
    wl[1] |=> live_q[1] == $past(wdata));
endmodule

// File: rtl/apwm_counter.sv
module apwm_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic [W-1:0] len,
  output logic [W-1:0] cnt,
  output logic         rollover
);
  // A length of 0 is treated as 1.
  function automatic logic [W-1:0] top_of(input logic [W-1:0] l);
    return (l == '0) ? W'(1) : l;
  endfunction

  logic [W-1:0] cnt_q;
  assign rollover = run && (cnt_q >= top_of(len));
  assign cnt = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt_q <= '0;
    else if (rollover) cnt_q <= '0;
    else if (run)      cnt_q <= cnt_q + W'(1);
  end

  // R3: halted counter holds
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> $stable(cnt_q));
  // R3: rollover returns to zero
  a_r3_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    rollover |=> cnt_q == '0);
  // R3: otherwise steps by one
  a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !rollover) |=> cnt_q == $past(cnt_q) + W'(1));
endmodule

// File: rtl/apwm_wave.sv
module apwm_wave #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] cnt,
  input  logic [W-1:0] cmp,
  input  logic         outen,
  input  logic         invert,
  output logic         pwm_out
);
  function automatic logic level(input logic [W-1:0] c, input logic [W-1:0] k,
                                 input logic inv);
    return (c < k) ^ inv;
  endfunction

  logic out_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_q <= 1'b0;
    else        out_q <= outen && level(cnt, cmp, invert);
  end
  assign pwm_out = out_q;

  // R6: gated output is low
  a_r6_gate_low: assert property (@(posedge clk) disable iff (!rst_n)
    !outen |=> !out_q);
  // R4: zero compare in normal polarity gives low
  a_r4_zero_cmp: assert property (@(posedge clk) disable iff (!rst_n)
    (outen && !invert && cmp == '0) |=> !out_q);
  // R5: zero compare inverted gives high
  a_r5_zero_inv: assert property (@(posedge clk) disable iff (!rst_n)
    (outen && invert && cmp == '0) |=> out_q);
endmodule

// File: rtl/apwm_top.sv
module apwm_top #(
  parameter int W  = 32,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [W-1:0]  bus_wdata,
  output logic [W-1:0]  bus_rdata,
  output logic          pwm_out
);
  logic [W-1:0] live_len, live_cmp, cnt;
  logic run, outen, invert, rollover;

  apwm_regs #(.W(W), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
    .rollover(rollover), .live_len(live_len), .live_cmp(live_cmp),
    .run(run), .outen(outen), .invert(invert), .rdata(bus_rdata));

  apwm_counter #(.W(W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run(run), .len(live_len),
    .cnt(cnt), .rollover(rollover));

  apwm_wave #(.W(W)) u_wave (
    .clk(clk), .rst_n(rst_n), .cnt(cnt), .cmp(live_cmp),
    .outen(outen), .invert(invert), .pwm_out(pwm_out));

  // R10: a zero length never lets the counter pass 1
  a_r10_min_len: assert property (@(posedge clk) disable iff (!rst_n)
    (run && live_len == '0 && cnt <= W'(1)) |=> cnt <= W'(1));
endmodule

// File: tb/sim_apwm_top.sv
`timescale 1ns/1ps
module sim_apwm_top;
  localparam int W = 32;
  localparam int AW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_we = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [W-1:0] bus_wdata = '0;
  logic [W-1:0] bus_rdata;
  logic pwm_out;

  apwm_top #(.W(W), .AW(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_out(pwm_out));

  always #5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  logic chk_en = 1'b0;
  string cur_req = "R4";

  // Reference model written from the requirements.
  logic [W-1:0] m_len, m_cmp, m_slen, m_scmp, m_cnt;
  logic [15:0]  m_ctrl;
  logic         m_pend, m_out;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_len <= '0; m_cmp <= '0; m_slen <= '0; m_scmp <= '0; m_cnt <= '0;
      m_ctrl <= '0; m_pend <= 1'b0; m_out <= 1'b0;
    end else begin
      logic [W-1:0] top;
      logic roll;
      top  = (m_len == 0) ? 1 : m_len;
      roll = m_ctrl[4] && (m_cnt >= top);
      if (m_ctrl[4]) m_cnt <= roll ? '0 : m_cnt + 1;
      m_out <= m_ctrl[9] ? ((m_cnt < m_cmp) ^ m_ctrl[10]) : 1'b0;
      if (roll && m_pend) begin
        m_len <= m_slen; m_cmp <= m_scmp; m_pend <= 1'b0;
      end
      if (bus_we) begin
        case (bus_addr)
          8'h08: m_len <= bus_wdata;
          8'h0C: m_cmp <= bus_wdata;
          8'h10: begin m_slen <= bus_wdata; m_pend <= 1'b1; end
          8'h14: begin m_scmp <= bus_wdata; m_pend <= 1'b1; end
          8'h2A: m_ctrl <= bus_wdata[15:0];
          default: ;
        endcase
      end
    end
  end

  always @(negedge clk) begin
    if (chk_en) begin
      checks++;
      if (pwm_out !== m_out) begin
        errors++;
        $display("FAIL %s pwm_out actual=%0b expected=%0b (len=%0d cmp=%0d ctrl=%h)",
                 cur_req, pwm_out, m_out, m_len, m_cmp, m_ctrl);
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [W-1:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [W-1:0] exp, input string req);
    @(negedge clk);
    bus_addr = a;
    #1;
    checks++;
    if (bus_rdata !== exp) begin
      errors++;
      $display("FAIL %s read @%h actual=%0h expected=%0h", req, a, bus_rdata, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  localparam logic [W-1:0] C_RUN = 32'h0010, C_EN = 32'h0200, C_INV = 32'h0400,
                           C_SYNC_OFF = 32'h00C0;

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    idle(3);
    // R1: reset state
    checks++;
    if (pwm_out !== 1'b0) begin
      errors++; $display("FAIL R1 pwm_out actual=%0b expected=0", pwm_out);
    end
    rd_chk(8'h08, 0, "R1"); rd_chk(8'h0C, 0, "R1"); rd_chk(8'h10, 0, "R1");
    rd_chk(8'h14, 0, "R1"); rd_chk(8'h2A, 0, "R1");
    @(negedge clk); rst_n = 1'b1;
    idle(2);

    // R2: readback of every register, control zero-extended, unmapped zero
    wr(8'h10, 32'hDEAD_BEEF); wr(8'h14, 32'h1234_5678);
    wr(8'h08, 32'hCAFE_0001); wr(8'h0C, 32'h0BAD_F00D);
    wr(8'h2A, 32'hFFFF_A5C3);
    rd_chk(8'h08, 32'hCAFE_0001, "R2"); rd_chk(8'h0C, 32'h0BAD_F00D, "R2");
    rd_chk(8'h10, 32'hDEAD_BEEF, "R2"); rd_chk(8'h14, 32'h1234_5678, "R2");
    rd_chk(8'h2A, 32'h0000_A5C3, "R2"); rd_chk(8'h04, 0, "R2");
    wr(8'h2A, 0);
    @(negedge clk); rst_n = 1'b0; idle(2); rst_n = 1'b1; idle(2);
    chk_en = 1'b1;

    // R4 / R5 / R10 sweep: every short length against every compare value
    for (int inv = 0; inv < 2; inv++) begin
      for (int len = 0; len <= 5; len++) begin
        for (int c = 0; c <= 7; c++) begin
          cur_req = (len == 0) ? "R10" : (inv != 0 ? "R5" : "R4");
          wr(8'h08, len); wr(8'h0C, c);
          wr(8'h2A, C_RUN | C_EN | C_SYNC_OFF | (inv != 0 ? C_INV : 0));
          idle(3 * (len + 2));
          // R3: halted counter freezes the waveform
          cur_req = "R3";
          wr(8'h2A, C_EN | (inv != 0 ? C_INV : 0));
          idle(4);
          // R6: writing 0 to control stops and drives low
          cur_req = "R6";
          wr(8'h2A, 0);
          idle(3);
        end
      end
    end

    // R7: stage a new pair in the middle of a long cycle
    cur_req = "R7";
    wr(8'h2A, 0); wr(8'h08, 9); wr(8'h0C, 3);
    @(negedge clk); rst_n = 1'b0; idle(1); rst_n = 1'b1;
    wr(8'h08, 9); wr(8'h0C, 3); wr(8'h2A, C_RUN | C_EN);
    idle(2);
    wr(8'h10, 4); wr(8'h14, 2);
    rd_chk(8'h08, 9, "R7"); rd_chk(8'h0C, 3, "R7");
    idle(12);
    rd_chk(8'h08, 4, "R7"); rd_chk(8'h0C, 2, "R7");
    idle(10);

    // R8: no fresh stage, so direct values survive several rollovers
    cur_req = "R8";
    wr(8'h08, 7);
    idle(25);
    rd_chk(8'h08, 7, "R8"); rd_chk(8'h0C, 2, "R8");

    // R9: direct compare write changes the waveform at once
    cur_req = "R9";
    wr(8'h0C, 6);
    rd_chk(8'h0C, 6, "R9");
    idle(10);
    wr(8'h0C, 0);
    idle(10);
    wr(8'h0C, 100);
    idle(10);

    chk_en = 1'b0;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule